// File: doc/BRIEF.md
# Sequential Multiply-Accumulate Unit

This unit multiplies two 32-bit register operands over several clock cycles. It offers six operations. Two produce only the lower word, either the plain product or the product plus a 32-bit addend. The other four produce the full 64-bit product split into an upper and a lower word, as signed or unsigned, with or without a 64-bit addend. It also derives a negative flag and a zero flag from each result.

The multiplier operand is consumed one byte per cycle. The loop stops as soon as the bits not yet consumed cannot change the product. For unsigned long forms that is when they are all zero. For the signed forms, and for the 32-bit forms whose lower word does not depend on signedness, it is when they are all zero or all one. A correction term covers the all-one case. A request therefore takes between two and five cycles, depending on the multiplier value.

Control is a plain request/busy/done handshake. A request pulse is taken only while `busy` is low, and that low level is the unit's only back-pressure. Operands, addend and operation are all sampled in the cycle the request is taken. The results and flags then hold until the next completion.

Top module: `mac_unit`

## Requirements
- R1: After reset, `busy` and `done` are low, `res_lo`, `res_hi` and `flag_n` are zero and `flag_z` is one.
- R2: Operation code 0 (and the spare codes 6 and 7) returns the lower 32 bits of `src_a*src_b` on `res_lo`, with `res_hi` zero.
- R3: Operation code 1 returns the lower 32 bits of `src_a*src_b + acc_lo` on `res_lo`, with `res_hi` zero.
- R4: Operation code 2 returns the unsigned 64-bit product, upper word on `res_hi` and lower word on `res_lo`.
- R5: Operation code 3 returns the two's-complement signed 64-bit product on `res_hi:res_lo`.
- R6: Operation codes 4 (unsigned) and 5 (signed) return the 64-bit product plus `{acc_hi,acc_lo}`, wrapped modulo 2^64.
- R7: Let k be the smallest number in 1..4 for which `src_b` shifted right by 8k bits is zero. The shift is logical for codes 2 and 4; for the other codes it is arithmetic, and an all-one result also counts. `done` is then high exactly k+1 cycles after the clock edge that takes the request, so latency is 2 to 5 cycles.
- R8: `busy` rises on the edge that takes a request and falls on the edge that raises `done`. `done` is a one-cycle pulse, and every accepted request gives exactly one `done`.
- R9: A request pulse while `busy` is high is ignored. Changes to operands, addend or operation code while busy do not affect the result in progress.
- R10: `res_lo`, `res_hi`, `flag_n` and `flag_z` change only on the edge that raises `done` and hold otherwise.
- R11: `flag_z` is one when the whole 64-bit result (`res_hi:res_lo`) is zero. `flag_n` is bit 31 of `res_lo` for codes 0, 1, 6 and 7, and bit 31 of `res_hi` for codes 2 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken when `busy` is low |
| op | input | 3 | Operation code, 0 to 7 |
| src_a | input | 32 | Multiplicand |
| src_b | input | 32 | Multiplier, sets the latency |
| acc_lo | input | 32 | Lower word of the addend |
| acc_hi | input | 32 | Upper word of the addend, long forms only |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | 32 | Lower result word |
| res_hi | output | 32 | Upper result word, zero for 32-bit forms |
| flag_n | output | 1 | Negative flag of the last result |
| flag_z | output | 1 | Zero flag of the last result |

## Verification
The bench aims at the operand extremes 0x80000000 and 0xFFFFFFFF in both signed and unsigned long forms. A design that mixed up sign extension and the all-one correction would be off by a shifted copy of the multiplicand in the upper word. Multipliers chosen to stop after one, two, three and four bytes check the latency. A design that terminated early on all-one bits for an unsigned multiply would drop a large partial product, and one that never terminated early would finish late. Accumulates that wrap past 2^32 and 2^64 and a signed result of exactly zero cover the addend and the flags. A request injected while busy and operand changes during the computation would corrupt the pending result if the unit did not lock its inputs on acceptance.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;

  typedef enum logic [2:0] {
    OP_MUL_LO  = 3'd0,
    OP_MAC_LO  = 3'd1,
    OP_MUL_U64 = 3'd2,
    OP_MUL_S64 = 3'd3,
    OP_MAC_U64 = 3'd4,
    OP_MAC_S64 = 3'd5,
    OP_SPARE6  = 3'd6,
    OP_SPARE7  = 3'd7
  } mac_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIN  = 2'd2
  } mac_state_e;

  // long forms deliver both words
  function automatic logic op_is_long(mac_op_e o);
    return (o == OP_MUL_U64) || (o == OP_MUL_S64) ||
           (o == OP_MAC_U64) || (o == OP_MAC_S64);
  endfunction

  // unsigned long forms must not stop on all-one remaining bits
  function automatic logic op_signed_term(mac_op_e o);
    return !((o == OP_MUL_U64) || (o == OP_MAC_U64));
  endfunction

  function automatic logic op_acc64(mac_op_e o);
    return (o == OP_MAC_U64) || (o == OP_MAC_S64);
  endfunction

endpackage

// File: rtl/mac_ctrl.sv
`timescale 1ns/1ps
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int MAX_ITER = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic term,
  output logic load,
  output logic iter_en,
  output logic fin_en,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(MAX_ITER + 1);

  mac_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic            done_q;

  assign load    = start && (state_q == ST_IDLE);
  assign iter_en = (state_q == ST_ITER);
  assign fin_en  = (state_q == ST_FIN);
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_FIN);
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_ITER;
            cnt_q   <= '0;
          end
        end
        ST_ITER: begin
          cnt_q <= cnt_q + 1'b1;
          // the bound is a safety net; term fires by the last digit anyway
          if (term || (cnt_q == CW'(MAX_ITER - 1))) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mac_iter.sv
`timescale 1ns/1ps
module mac_iter #(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  iter_en,
  input  logic                  sgn_in,
  input  logic [DATA_W-1:0]     a,
  input  logic [DATA_W-1:0]     b,
  output logic [2*DATA_W-1:0]   part_q,
  output logic [2*DATA_W-1:0]   mcand_q,
  output logic [DATA_W-1:0]     mplier_q,
  output logic                  sgn_q,
  output logic                  term
);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] mplier_nxt;
  logic [PROD_W-1:0] digit_prod;
  logic [PROD_W-1:0] a_ext;

  assign a_ext = sgn_in ? {{DATA_W{a[DATA_W-1]}}, a} : {{DATA_W{1'b0}}, a};

  assign mplier_nxt = sgn_q ? DATA_W'($signed(mplier_q) >>> DIGIT_W)
                            : (mplier_q >> DIGIT_W);

  assign digit_prod = mcand_q * PROD_W'(mplier_q[DIGIT_W-1:0]);

  // nothing left to contribute, or only a sign run fixed up at the end
  assign term = (mplier_nxt == '0) || (sgn_q && (&mplier_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q   <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      sgn_q    <= 1'b0;
    end else if (load) begin
      part_q   <= '0;
      mcand_q  <= a_ext;
      mplier_q <= b;
      sgn_q    <= sgn_in;
    end else if (iter_en) begin
      part_q   <= part_q + digit_prod;
      mcand_q  <= mcand_q << DIGIT_W;
      mplier_q <= mplier_nxt;
    end
  end

endmodule

// File: rtl/mac_final.sv
`timescale 1ns/1ps
module mac_final
  import mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  mac_op_e               op,
  input  logic [2*DATA_W-1:0]   part,
  input  logic [2*DATA_W-1:0]   mcand,
  input  logic [DATA_W-1:0]     mplier,
  input  logic                  sgn,
  input  logic [2*DATA_W-1:0]   acc,
  output logic [DATA_W-1:0]     lo,
  output logic [DATA_W-1:0]     hi,
  output logic                  neg,
  output logic                  zero
);
  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] corr;
  logic [PROD_W-1:0] addend;
  logic [PROD_W-1:0] total;
  logic              is_long;

  assign is_long = op_is_long(op);

  // remaining all-one multiplier bits stand for minus one times the shifted multiplicand
  assign corr = (sgn && (&mplier)) ? mcand : '0;

  always_comb begin
    if (op_acc64(op))           addend = acc;
    else if (op == OP_MAC_LO)   addend = {{DATA_W{1'b0}}, acc[DATA_W-1:0]};
    else                        addend = '0;
  end

  assign total = part - corr + addend;

  assign lo   = total[DATA_W-1:0];
  assign hi   = is_long ? total[PROD_W-1:DATA_W] : '0;
  assign neg  = is_long ? total[PROD_W-1] : total[DATA_W-1];
  assign zero = is_long ? (total == '0) : (total[DATA_W-1:0] == '0);

endmodule

// File: rtl/mac_unit.sv
`timescale 1ns/1ps
module mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] acc_lo,
  input  logic [DATA_W-1:0] acc_hi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi,
  output logic              flag_n,
  output logic              flag_z
);
  localparam int MAX_ITER = DATA_W / DIGIT_W;
  localparam int PROD_W   = 2 * DATA_W;

  logic                load, iter_en, fin_en, term;
  logic [PROD_W-1:0]   part_q, mcand_q, acc_q;
  logic [DATA_W-1:0]   mplier_q;
  logic                sgn_q;
  mac_op_e             op_q;
  logic [DATA_W-1:0]   f_lo, f_hi;
  logic                f_neg, f_zero;

  mac_ctrl #(.MAX_ITER(MAX_ITER)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .term    (term),
    .load    (load),
    .iter_en (iter_en),
    .fin_en  (fin_en),
    .busy    (busy),
    .done    (done)
  );

  mac_iter #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) i_iter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .iter_en  (iter_en),
    .sgn_in   (op_signed_term(mac_op_e'(op))),
    .a        (src_a),
    .b        (src_b),
    .part_q   (part_q),
    .mcand_q  (mcand_q),
    .mplier_q (mplier_q),
    .sgn_q    (sgn_q),
    .term     (term)
  );

  mac_final #(.DATA_W(DATA_W)) i_final (
    .op     (op_q),
    .part   (part_q),
    .mcand  (mcand_q),
    .mplier (mplier_q),
    .sgn    (sgn_q),
    .acc    (acc_q),
    .lo     (f_lo),
    .hi     (f_hi),
    .neg    (f_neg),
    .zero   (f_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_MUL_LO;
      acc_q  <= '0;
      res_lo <= '0;
      res_hi <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b1;
    end else begin
      if (load) begin
        op_q  <= mac_op_e'(op);
        acc_q <= {acc_hi, acc_lo};
      end
      if (fin_en) begin
        res_lo <= f_lo;
        res_hi <= f_hi;
        flag_n <= f_neg;
        flag_z <= f_zero;
      end
    end
  end

endmodule

// File: rtl/mac_unit_chk.sv
`timescale 1ns/1ps
module mac_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int MAX_ITER = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] res_lo,
  input logic [DATA_W-1:0] res_hi,
  input logic              flag_z
);
  logic [3:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_q <= '0;
    else if (busy) lat_q <= lat_q + 1'b1;
    else           lat_q <= '0;
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);  // R8
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);  // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_lo) && $stable(res_hi) && $stable(flag_z)));  // R10
  AST_LAT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lat_q <= 4'(MAX_ITER)));  // R7
  AST_LAT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q >= 4'd2));  // R7
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z == ((res_lo == '0) && (res_hi == '0)));  // R11

endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W), .MAX_ITER(DATA_W / DIGIT_W)) i_mac_unit_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .res_lo (res_lo),
  .res_hi (res_hi),
  .flag_z (flag_z)
);

// File: tb/test_mac_unit.sv
`timescale 1ns/1ps
module test_mac_unit;

  typedef struct {
    logic [31:0] lo;
    logic [31:0] hi;
    logic        n;
    logic        z;
    int          lat;
    longint      t0;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] src_a = '0, src_b = '0, acc_lo = '0, acc_hi = '0;
  logic        busy, done, flag_n, flag_z;
  logic [31:0] res_lo, res_hi;

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  exp_t   sb[$];
  exp_t   last;

  always #5 clk = ~clk;

  mac_unit i_mac_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_a(src_a), .src_b(src_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
    .busy(busy), .done(done), .res_lo(res_lo), .res_hi(res_hi),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Reference built from the requirement text (R2..R7, R11)
  function automatic exp_t model(logic [2:0] o, logic [31:0] a, logic [31:0] b,
                                 logic [31:0] ah, logic [31:0] al, string tag);
    exp_t        e;
    logic [63:0] pu, ps, r;
    logic [31:0] rem;
    logic        lng, sgn;
    int          k;
    pu  = {32'b0, a} * {32'b0, b};
    ps  = 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}));
    lng = (o >= 3'd2) && (o <= 3'd5);
    sgn = !((o == 3'd2) || (o == 3'd4));
    case (o)
      3'd1:    r = {32'b0, pu[31:0] + al};
      3'd2:    r = pu;
      3'd3:    r = ps;
      3'd4:    r = pu + {ah, al};
      3'd5:    r = ps + {ah, al};
      default: r = {32'b0, pu[31:0]};
    endcase
    k = 4;
    for (int i = 1; i <= 3; i++) begin
      rem = sgn ? 32'($signed(b) >>> (8 * i)) : (b >> (8 * i));
      if ((rem == 32'h0) || (sgn && rem == 32'hFFFF_FFFF)) begin
        k = i;
        break;
      end
    end
    e.lo  = r[31:0];
    e.hi  = r[63:32];
    e.n   = lng ? r[63] : r[31];
    e.z   = (r == 64'h0);
    e.lat = k + 1;
    e.t0  = 0;
    e.tag = tag;
    return e;
  endfunction

  // Driver: one request; inject=1 adds a second pulse and changes inputs while busy (R9)
  task automatic issue(logic [2:0] o, logic [31:0] a, logic [31:0] b,
                       logic [31:0] ah, logic [31:0] al, string tag, bit inject = 0);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e = model(o, a, b, ah, al, tag);
    e.t0 = cyc + 1;
    sb.push_back(e);
    op = o; src_a = a; src_b = b; acc_hi = ah; acc_lo = al; start = 1'b1;
    @(negedge clk);
    if (inject) begin
      op = 3'd5; src_a = 32'h1234_5678; src_b = 32'h7FFF_0001;
      acc_hi = 32'hDEAD_BEEF; acc_lo = 32'hCAFE_F00D;
      start = 1'b1;
      @(negedge clk);
      src_b = 32'h0000_0003;
      start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk("R8", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "res_lo", {32'b0, res_lo}, {32'b0, e.lo});
        chk(e.tag, "res_hi", {32'b0, res_hi}, {32'b0, e.hi});
        chk("R11", "flag_n", {63'b0, flag_n}, {63'b0, e.n});
        chk("R11", "flag_z", {63'b0, flag_z}, {63'b0, e.z});
        chk("R7", "latency", 64'(cyc - e.t0), 64'(e.lat));
        chk("R8", "busy low with done", {63'b0, busy}, 64'd0);
        last = e;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "busy", {63'b0, busy}, 64'd0);
    chk("R1", "done", {63'b0, done}, 64'd0);
    chk("R1", "result", {res_hi, res_lo}, 64'd0);
    chk("R1", "flags", {62'b0, flag_n, flag_z}, 64'd1);
    rst_n = 1'b1;

    // R2 lower word only, plus latency extremes for R7
    issue(3'd0, 32'd3, 32'd5, 32'h0, 32'h0, "R2");
    issue(3'd0, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 32'h0, "R2");
    issue(3'd0, 32'h1234_5678, 32'h0, 32'h0, 32'h0, "R2");
    issue(3'd0, 32'h89AB_CDEF, 32'h1234_5678, 32'h0, 32'h0, "R2");
    issue(3'd0, 32'h0000_7001, 32'hFFFF_FF80, 32'h0, 32'h0, "R2");
    issue(3'd6, 32'hFFFF_FFFF, 32'h0001_0003, 32'h0, 32'h0, "R2");
    issue(3'd7, 32'h0000_0100, 32'h0100_0000, 32'h0, 32'h0, "R2");
    // R3 accumulate into the lower word, with wrap
    issue(3'd1, 32'hFFFF_FFFF, 32'd2, 32'hAAAA_AAAA, 32'd5, "R3");
    issue(3'd1, 32'd7, 32'd9, 32'h0, 32'hFFFF_FFC1, "R3");
    // R4 unsigned long
    issue(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, "R4");
    issue(3'd2, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, "R4");
    issue(3'd2, 32'hDEAD_BEEF, 32'h0000_01FF, 32'h0, 32'h0, "R4");
    issue(3'd2, 32'h0000_0001, 32'hFFFF_FF80, 32'h0, 32'h0, "R4");
    // R5 signed long
    issue(3'd3, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 32'h0, "R5");
    issue(3'd3, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, "R5");
    issue(3'd3, 32'hFFFF_FFFD, 32'd7, 32'h0, 32'h0, "R5");
    issue(3'd3, 32'h7FFF_FFFF, 32'hFFFF_FF80, 32'h0, 32'h0, "R5");
    issue(3'd3, 32'hFFFF_FFFF, 32'h0000_7FFF, 32'h0, 32'h0, "R5");
    // R6 long accumulate with 64-bit wrap; signed one gives exact zero for R11
    issue(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    issue(3'd4, 32'h0001_0000, 32'h0001_0000, 32'h0000_0001, 32'h8000_0000, "R6");
    issue(3'd5, 32'hFFFF_FFFF, 32'd1, 32'h0, 32'd1, "R6");
    issue(3'd5, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0000, 32'h0000_0010, "R6");
    wait_idle();

    // R9: extra pulse and input changes while busy are ignored
    issue(3'd2, 32'h0000_0011, 32'h0000_0002, 32'h0, 32'h0, "R9", 1'b1);
    wait_idle();
    issue(3'd3, 32'hFFFF_FFFE, 32'h1234_5678, 32'h0, 32'h0, "R9", 1'b1);
    wait_idle();

    // R10: outputs hold while idle after done
    repeat (4) @(negedge clk);
    chk("R10", "hold res_lo", {32'b0, res_lo}, {32'b0, last.lo});
    chk("R10", "hold res_hi", {32'b0, res_hi}, {32'b0, last.hi});
    chk("R10", "hold flags", {62'b0, flag_n, flag_z}, {62'b0, last.n, last.z});
    chk("R8", "idle not busy", {63'b0, busy}, 64'd0);

    repeat (5) @(negedge clk);
    chk("R8", "pending results", 64'(sb.size()), 64'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule